// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external bus master read and write a small bank of 8-bit configuration registers. SCL and SDA are brought in through a two-flop synchroniser. Bus events are decoded from the synchronised levels: START and STOP are SDA edges while SCL is high, and data bits are taken at SCL edges. The target answers a 7-bit device address. The upper five bits of that address are a parameter and the lower two come from strap pins, so up to four copies can share one bus.

A write transaction carries one subaddress byte, which loads an internal pointer. It may then carry any number of data bytes. Each data byte lands at the pointer, and the pointer then advances. A read reached through a repeated START after the subaddress returns data from that subaddress onward. A read that has no subaddress phase in the same transaction starts at offset 00h. The target pulls SDA low only through an open-drain enable. Reserved bit positions are declared per register by a mask parameter. They are never stored and always read as zero. The register contents are presented to the rest of the chip as one flat vector.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal {ADDR_HI, strap_i}. Any other address is not acknowledged. The target then leaves SDA released and changes no register until the next START.
- R2: After an acknowledged address with R/W bit 0 (bit 0 of the address byte, 0 = write), the next byte is taken MSB-first as the register pointer and is acknowledged.
- R3: Every further byte of a write is acknowledged and stored at the current pointer, and the pointer then increments by one. No register changes without such a byte.
- R4: Bits set in RSV_MASK (register n occupies bits 8n+7..8n) are never written and always read as 0, both on regs_o and over the bus.
- R5: A repeated START with R/W bit 1 that follows a subaddress phase returns register data MSB-first, starting at that subaddress.
- R6: After each read byte the master's acknowledge is sampled. On ACK (SDA low) the next register is sent. On NACK the target keeps SDA released until the next START or STOP.
- R7: A read with no subaddress phase since the last STOP starts at offset 00h and increments one byte at a time.
- R8: At pointer values of NUM_REGS and above, written bytes are acknowledged but discarded, and reads return 00h.
- R9: A STOP releases SDA and returns the target to idle.
- R10: sda_oe_o changes only in response to a falling SCL edge, so SDA never moves while SCL is high.
- R11: Reset clears every register to 00h and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Low two bits of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | All registers, register n in bits 8n+7..8n |

## Verification
A wrong pointer shows up in the register read back over the bus at the very next byte, or as a changed regs_o field one system clock after a written byte's last bit. A wrong protocol state shows up at the next acknowledge slot as a missing or unexpected low on SDA. A bad bit count shifts every later byte of the transaction, so it is visible within nine SCL periods. A stale "subaddress seen" flag shows up as a read that starts at the wrong offset in the first byte after the address.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_SLV_ACK,
        ST_RDATA,
        ST_MST_ACK,
        ST_IGNORE
    } tgt_state_e;

    typedef enum logic [1:0] {
        NX_SUB,
        NX_WDATA,
        NX_READ
    } ack_next_e;

    typedef struct packed {
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef struct packed {
        logic  en;
        ptr_t  addr;
        byte_t data;
    } wr_req_t;

    function automatic logic [6:0] dev_addr(logic [4:0] hi, logic [1:0] strap);
        return {hi, strap};
    endfunction

    function automatic ptr_t ptr_next(ptr_t p);
        return p + ptr_t'(1);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_rb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_p;
    logic [DEPTH-1:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[DEPTH-2:0], scl_i};
            sda_p <= {sda_p[DEPTH-2:0], sda_i};
        end
    end

    logic scl_now, scl_was, sda_now, sda_was;
    assign scl_now = scl_p[STAGES-1];
    assign scl_was = scl_p[STAGES];
    assign sda_now = sda_p[STAGES-1];
    assign sda_was = sda_p[STAGES];

    always_comb begin
        ev.sda   = sda_now;
        ev.rise  = scl_now & ~scl_was;
        ev.fall  = ~scl_now & scl_was;
        ev.start = scl_now & scl_was & sda_was & ~sda_now;
        ev.stop  = scl_now & scl_was & ~sda_was & sda_now;
    end

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
    import i2c_rb_pkg::*;
#(
    parameter int                     NUM_REGS = 4,
    parameter logic [NUM_REGS*8-1:0]  RSV_MASK = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    input  ptr_t                     rd_addr,
    output byte_t                    rd_data,
    output logic [NUM_REGS*8-1:0]    regs_flat
);
    byte_t q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam byte_t KEEP = byte_t'(~RSV_MASK[i*BYTE_W +: BYTE_W]);

        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (wr.en && (int'(wr.addr) == i)) begin
                q[i] <= wr.data & KEEP;
            end
        end

        assign regs_flat[i*BYTE_W +: BYTE_W] = q[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(rd_addr) == i) begin
                rd_data = q[i] & ~RSV_MASK[i*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_rb_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b10110
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [1:0] strap_i,
    input  byte_t      rd_data,
    output logic       sda_oe,
    output wr_req_t    wr,
    output ptr_t       rd_addr,
    output tgt_state_e state
);
    ack_next_e  nxt;
    byte_t      shreg;
    byte_t      tx;
    logic [3:0] cnt;
    ptr_t       ptr;
    logic       sub_seen;
    logic       mack;

    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            nxt      <= NX_SUB;
            shreg    <= '0;
            tx       <= '0;
            cnt      <= '0;
            ptr      <= '0;
            sub_seen <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                sub_seen <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (ev.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (ev.fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == dev_addr(ADDR_HI, strap_i)) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_SLV_ACK;
                                    if (shreg[0]) begin
                                        nxt <= NX_READ;
                                        if (!sub_seen) begin
                                            ptr <= '0;
                                        end
                                    end else begin
                                        nxt <= NX_SUB;
                                    end
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_SUB) begin
                                ptr      <= shreg;
                                sub_seen <= 1'b1;
                                sda_oe   <= 1'b1;
                                nxt      <= NX_WDATA;
                                state    <= ST_SLV_ACK;
                            end else begin
                                wr     <= '{en: 1'b1, addr: ptr, data: shreg};
                                ptr    <= ptr_next(ptr);
                                sda_oe <= 1'b1;
                                nxt    <= NX_WDATA;
                                state  <= ST_SLV_ACK;
                            end
                        end
                    end
                    ST_SLV_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            unique case (nxt)
                                NX_SUB: begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_SUB;
                                end
                                NX_WDATA: begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_WDATA;
                                end
                                NX_READ: begin
                                    tx     <= rd_data;
                                    ptr    <= ptr_next(ptr);
                                    sda_oe <= ~rd_data[BYTE_W-1];
                                    state  <= ST_RDATA;
                                end
                                default: state <= ST_IGNORE;
                            endcase
                        end
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            if (cnt == 4'd7) begin
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                state  <= ST_MST_ACK;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_MST_ACK: begin
                        if (ev.rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (mack) begin
                                tx     <= rd_data;
                                ptr    <= ptr_next(ptr);
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_rb_pkg::*;
#(
    parameter logic [4:0]             ADDR_HI     = 5'b10110,
    parameter int                     NUM_REGS    = 4,
    parameter logic [NUM_REGS*8-1:0]  RSV_MASK    = 32'hF000_8100,
    parameter int                     SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic [1:0]              strap_i,
    output logic                    sda_oe_o,
    output logic [NUM_REGS*8-1:0]   regs_o
);
    bus_ev_t    ev;
    wr_req_t    wr;
    ptr_t       rd_addr;
    byte_t      rd_data;
    tgt_state_e fsm_state;

    logic mon_fall, mon_stop, mon_wr_en;
    ptr_t mon_wr_addr;
    assign mon_fall    = ev.fall;
    assign mon_stop    = ev.stop;
    assign mon_wr_en   = wr.en;
    assign mon_wr_addr = wr.addr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap_i (strap_i),
        .rd_data (rd_data),
        .sda_oe  (sda_oe_o),
        .wr      (wr),
        .rd_addr (rd_addr),
        .state   (fsm_state)
    );

    i2c_reg_file #(.NUM_REGS(NUM_REGS), .RSV_MASK(RSV_MASK)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk
    import i2c_rb_pkg::*;
#(
    parameter int                     NUM_REGS = 4,
    parameter logic [NUM_REGS*8-1:0]  RSV_MASK = '0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sda_oe_o,
    input logic [NUM_REGS*8-1:0]  regs_o,
    input logic                   mon_fall,
    input logic                   mon_stop,
    input logic                   mon_wr_en,
    input ptr_t                   mon_wr_addr,
    input tgt_state_e             fsm_state
);
    AST_IGNORED_NO_DRIVE: assert property (@(posedge clk) disable iff (rst) (fsm_state == ST_IGNORE) |-> !sda_oe_o); // R1
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst) !mon_wr_en |=> $stable(regs_o)); // R3
    AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (rst) (regs_o & RSV_MASK) == '0); // R4
    AST_OOR_DISCARD: assert property (@(posedge clk) disable iff (rst) (mon_wr_en && int'(mon_wr_addr) >= NUM_REGS) |=> $stable(regs_o)); // R8
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst) mon_stop |=> (!sda_oe_o && fsm_state == ST_IDLE)); // R9
    AST_SDA_ON_FALL: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe_o) |-> $past(mon_fall)); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (regs_o == '0 && !sda_oe_o)); // R11
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(
    .NUM_REGS (NUM_REGS),
    .RSV_MASK (RSV_MASK)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sda_oe_o    (sda_oe_o),
    .regs_o      (regs_o),
    .mon_fall    (mon_fall),
    .mon_stop    (mon_stop),
    .mon_wr_en   (mon_wr_en),
    .mon_wr_addr (mon_wr_addr),
    .fsm_state   (fsm_state)
);

// File: tb/i2c_regbank_target_tb_top.sv
module i2c_regbank_target_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          Q          = 8;
    localparam int          WATCHDOG   = 190000;
    localparam logic [4:0]  ADDR_HI    = 5'b10110;
    localparam int          NUM_REGS   = 4;
    localparam logic [31:0] RSV_MASK   = 32'hF000_8100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b01;
    logic        sda_oe;
    logic [31:0] regs;
    wire         sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    int r10_viol = 0;
    logic prev_oe = 1'b0;

    logic [7:0] model [NUM_REGS];
    logic       ack;
    logic [7:0] d;
    logic [31:0] snap;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_target #(
        .ADDR_HI  (ADDR_HI),
        .NUM_REGS (NUM_REGS),
        .RSV_MASK (RSV_MASK)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    // R10 monitor: SDA drive must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && (sda_oe !== prev_oe) && scl) r10_viol = r10_viol + 1;
        prev_oe = sda_oe;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] keep(int i);
        return ~RSV_MASK[i*8 +: 8];
    endfunction

    function automatic logic [31:0] model_flat();
        logic [31:0] f;
        for (int i = 0; i < NUM_REGS; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    function automatic logic [7:0] model_rd(int p);
        return (p < NUM_REGS) ? model[p] : 8'h00;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(logic b);
        sda_m = b;  tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        b = sda_line; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic xmit(input logic [7:0] v, output logic a);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        a = ~b;
    endtask

    task automatic recv(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~mack);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_REGS; i++) model[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(4);

        // R11 reset state
        chk("R11", "registers after reset", regs, 32'h0);
        chk("R11", "sda released after reset", {31'b0, sda_oe}, 32'h0);

        // R1 full address sweep with strap 10
        strap = 2'b10;
        tick(2);
        for (int a = 0; a < 128; a++) begin
            bus_start();
            xmit({a[6:0], 1'b0}, ack);
            bus_stop();
            chk("R1", "address sweep ack", {31'b0, ack},
                {31'b0, (a[6:0] == {ADDR_HI, 2'b10})});
        end

        // R1 every strap value against every low-bit combination
        for (int s = 0; s < 4; s++) begin
            strap = s[1:0];
            tick(2);
            for (int k = 0; k < 4; k++) begin
                bus_start();
                xmit({ADDR_HI, k[1:0], 1'b0}, ack);
                bus_stop();
                chk("R1", "strap match ack", {31'b0, ack}, {31'b0, (k == s)});
            end
        end

        // R1 mismatched address: following bytes ignored
        strap = 2'b01;
        tick(2);
        bus_start();
        xmit({ADDR_HI, 2'b11, 1'b0}, ack);
        chk("R1", "foreign address nack", {31'b0, ack}, 32'h0);
        xmit(8'h00, ack);
        chk("R1", "byte after foreign address nack", {31'b0, ack}, 32'h0);
        xmit(8'hFF, ack);
        chk("R1", "data after foreign address nack", {31'b0, ack}, 32'h0);
        bus_stop();
        chk("R1", "registers untouched by foreign access", regs, model_flat());

        // R2 R3 R4 R8 burst writes from subaddress 0 running past the bank
        for (int p = 0; p < 5; p++) begin
            bus_start();
            xmit({ADDR_HI, strap, 1'b0}, ack);
            chk("R2", "write address ack", {31'b0, ack}, 32'h1);
            xmit(8'h00, ack);
            chk("R2", "subaddress ack", {31'b0, ack}, 32'h1);
            for (int i = 0; i < NUM_REGS + 2; i++) begin
                d = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : 8'(p*53 + i*29 + 7);
                xmit(d, ack);
                chk((i < NUM_REGS) ? "R3" : "R8", "data byte ack", {31'b0, ack}, 32'h1);
                if (i < NUM_REGS) model[i] = d & keep(i);
            end
            bus_stop();
            chk("R4", "bank after burst write", regs, model_flat());
        end

        // R2 single write at subaddress 2
        bus_start();
        xmit({ADDR_HI, strap, 1'b0}, ack);
        xmit(8'h02, ack);
        xmit(8'hC3, ack);
        bus_stop();
        model[2] = 8'hC3 & keep(2);
        chk("R2", "single write at subaddress 2", regs, model_flat());

        // R8 write entirely beyond the bank leaves registers alone
        snap = regs;
        bus_start();
        xmit({ADDR_HI, strap, 1'b0}, ack);
        xmit(8'h09, ack);
        xmit(8'h77, ack);
        chk("R8", "out-of-range write ack", {31'b0, ack}, 32'h1);
        bus_stop();
        chk("R8", "out-of-range write discarded", regs, snap);

        // R5 R6 R8 combined reads from every start offset
        for (int s = 0; s < NUM_REGS + 2; s++) begin
            bus_start();
            xmit({ADDR_HI, strap, 1'b0}, ack);
            xmit(s[7:0], ack);
            bus_start();
            xmit({ADDR_HI, strap, 1'b1}, ack);
            chk("R5", "read address ack", {31'b0, ack}, 32'h1);
            for (int j = 0; j < 3; j++) begin
                recv(j < 2, d);
                chk((s + j < NUM_REGS) ? "R5" : "R8", "combined read byte",
                    {24'b0, d}, {24'b0, model_rd(s + j)});
            end
            recv(1'b1, d);
            chk("R6", "bus silent after nack", {24'b0, d}, 32'hFF);
            bus_stop();
            chk("R9", "sda released after stop", {31'b0, sda_oe}, 32'h0);
        end

        // R7 read with no subaddress phase starts at 00h
        bus_start();
        xmit({ADDR_HI, strap, 1'b1}, ack);
        chk("R7", "plain read address ack", {31'b0, ack}, 32'h1);
        for (int j = 0; j < NUM_REGS + 1; j++) begin
            recv(j < NUM_REGS, d);
            chk("R7", "plain read byte", {24'b0, d}, {24'b0, model_rd(j)});
        end
        bus_stop();
        chk("R9", "idle after final stop", {31'b0, sda_oe}, 32'h0);

        chk("R10", "sda drive changes while scl high", r10_viol, 32'h0);

        summary();
        $finish;
    end

endmodule